// File: doc/BRIEF.md
# Line-Bounded Fetch Address Generator

This block turns a granted wavefront into one instruction-fetch translation request. It takes the wavefront's program counter, its base pointer, its slot index and the byte sizes of the instructions already in its instruction buffer. It adds the base, the program counter and the sizes of the buffered instructions to get the virtual fetch address. The fetch then starts after the instructions that are already held, so nothing is fetched twice. The request length runs from that address to the end of its cache line and never further. A misaligned fetch is cut short at the line end and is never split into two requests. An aligned fetch asks for one whole line.

The request goes out on a valid/ready translation port and carries the slot index as a routing tag. A request the port refuses is parked in a small in-order retry queue, and the block becomes stalled. While it is stalled, new grants are not offered to the port. They go to the back of the queue, and the port sees the oldest queued request. Once the queue has drained, the stall lifts and new grants go straight to the port again. The fetch scheduler may only grant while `reqReady` is high.

Top module: `fag_top`

## Requirements
- R1: After reset `txValid` is 0, `reqReady` is 1 and no request is pending.
- R2: The fetch address is `reqBase + reqPc + S` modulo 2^ADDR_W. S is the sum of the first `bufCount` instruction sizes, where size i sits in `bufSizes[i*SZ_W +: SZ_W]`.
- R3: Let A be the fetch address and L the line size (a power of two). The split point is (A + L - 1) rounded down to a multiple of L, computed one bit wider than the address so it cannot wrap. The byte count is the split point minus A when the split point is above A, and L otherwise. A request therefore never crosses a line, even at the top of the address space.
- R4: While not stalled, a grant (`reqValid`) is offered on the port in the same cycle, with `txTag` equal to `reqSlot`.
- R5: If the port refuses a request that was offered directly, the request enters the retry queue and the block is stalled from the next cycle.
- R6: While stalled, the port offers the oldest queued request, and every accepted grant is appended to the queue instead of being offered.
- R7: Queued requests drain oldest first, one per cycle in which `txReady` is high. The stall clears when the queue becomes empty, and from the following cycle grants are offered directly again.
- R8: `reqReady` is 0 exactly when the retry queue is full. A grant presented while `reqReady` is 0 is ignored and never reaches the port.
- R9: A request offered with `txReady` low is offered again in the next cycle with the same address, byte count and tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A wavefront is granted for fetch this cycle |
| reqReady | output | 1 | Grant can be taken (retry queue not full) |
| reqPc | input | ADDR_W | Program counter of the granted wavefront |
| reqBase | input | ADDR_W | Base pointer of the granted wavefront |
| reqSlot | input | SLOT_W | Slot index of the granted wavefront |
| bufCount | input | CNT_W | Number of instructions currently buffered |
| bufSizes | input | BUF_DEPTH*SZ_W | Byte size of each buffered instruction, entry 0 lowest |
| txValid | output | 1 | Translation request valid |
| txReady | input | 1 | Translation port accepts the request |
| txAddr | output | ADDR_W | Virtual fetch address |
| txBytes | output | log2(LINE_BYTES)+1 | Bytes requested, 1 to LINE_BYTES |
| txTag | output | SLOT_W | Slot index used to route the return |

## Verification
The assertions check four things on every cycle. A refused request is held stable. Every offered request stays inside one line. A stall only ends on a cycle in which the port took a request. A full queue always goes with a stall that keeps the port busy. The address arithmetic, the sizes summed up to `bufCount`, the wrap at the top of the address space, the oldest-first drain and the dropping of grants made while `reqReady` is low are shown only by the bench. Its queue-based model predicts the port values in every cycle of the directed and random scenarios.

// File: rtl/fag_pkg.sv
package fag_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic push;      // write the new request into the retry queue
    logic pop;       // retire the queue head
    logic selQueue;  // port shows queue head instead of the new request
  } fagStrobes_t;
endpackage

// File: rtl/fag_datapath.sv
module fag_datapath #(
  parameter int ADDR_W     = 32,
  parameter int SLOT_W     = 4,
  parameter int BUF_DEPTH  = 5,
  parameter int SZ_W       = 4,
  parameter int CNT_W      = 3,
  parameter int LINE_BYTES = 64,
  parameter int Q_DEPTH    = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  fag_pkg::fagStrobes_t        strobes,
  input  logic [ADDR_W-1:0]           reqPc,
  input  logic [ADDR_W-1:0]           reqBase,
  input  logic [SLOT_W-1:0]           reqSlot,
  input  logic [CNT_W-1:0]            bufCount,
  input  logic [BUF_DEPTH*SZ_W-1:0]   bufSizes,
  output logic [ADDR_W-1:0]           txAddr,
  output logic [$clog2(LINE_BYTES):0] txBytes,
  output logic [SLOT_W-1:0]           txTag,
  output logic                        qFull,
  output logic                        qLast
);
  localparam int LB      = $clog2(LINE_BYTES);
  localparam int BYTES_W = LB + 1;
  localparam int EXT_W   = ADDR_W + 1;
  localparam int QP_W    = (Q_DEPTH > 1) ? $clog2(Q_DEPTH) : 1;
  localparam int QC_W    = $clog2(Q_DEPTH + 1);

  typedef struct packed {
    logic [ADDR_W-1:0]  addr;
    logic [BYTES_W-1:0] bytes;
    logic [SLOT_W-1:0]  tag;
  } entry_t;

  // Sum of the sizes of the buffered instructions
  logic [ADDR_W-1:0] partial [BUF_DEPTH+1];
  assign partial[0] = '0;
  for (genvar g = 0; g < BUF_DEPTH; g++) begin : gSum
    assign partial[g+1] = partial[g] +
      ((CNT_W'(g) < bufCount) ? ADDR_W'(bufSizes[g*SZ_W +: SZ_W]) : '0);
  end

  logic [ADDR_W-1:0] newAddr;
  logic [EXT_W-1:0]  addrExt, splitExt, lineMask;
  logic [BYTES_W-1:0] newBytes;
  entry_t newEntry;

  always_comb begin
    newAddr  = reqBase + reqPc + partial[BUF_DEPTH];
    addrExt  = {1'b0, newAddr};
    lineMask = EXT_W'(LINE_BYTES - 1);
    splitExt = (addrExt + lineMask) & ~lineMask;
    if (splitExt > addrExt) newBytes = BYTES_W'(splitExt - addrExt);
    else                    newBytes = BYTES_W'(LINE_BYTES);
    newEntry = '{addr: newAddr, bytes: newBytes, tag: reqSlot};
  end

  // Retry queue
  entry_t          store [Q_DEPTH];
  logic [QP_W-1:0] wrPtr, rdPtr;
  logic [QC_W-1:0] count;

  function automatic logic [QP_W-1:0] nextPtr(input logic [QP_W-1:0] p);
    return (p == QP_W'(Q_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push) store[wrPtr] <= newEntry;
  end

  entry_t outEntry;
  assign outEntry = strobes.selQueue ? store[rdPtr] : newEntry;
  assign txAddr   = outEntry.addr;
  assign txBytes  = outEntry.bytes;
  assign txTag    = outEntry.tag;
  assign qFull    = (count == QC_W'(Q_DEPTH));
  assign qLast    = (count == QC_W'(1));
endmodule

// File: rtl/fag_control.sv
module fag_control (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 txReady,
  input  logic                 qFull,
  input  logic                 qLast,
  output fag_pkg::fagStrobes_t strobes,
  output logic                 reqReady,
  output logic                 txValid,
  output logic                 stallQ
);
  logic accept;

  always_comb begin
    reqReady         = !qFull;
    accept           = reqValid && reqReady;
    txValid          = stallQ || reqValid;
    strobes.selQueue = stallQ;
    strobes.pop      = stallQ && txReady;
    strobes.push     = accept && (stallQ || !txReady);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       stallQ <= 1'b0;
    else if (stallQ) stallQ <= !(qLast && strobes.pop && !strobes.push);
    else             stallQ <= reqValid && !txReady;
  end
endmodule

// File: rtl/fag_top.sv
module fag_top #(
  parameter int ADDR_W     = 32,
  parameter int SLOT_W     = 4,
  parameter int BUF_DEPTH  = 5,
  parameter int SZ_W       = 4,
  parameter int LINE_BYTES = 64,
  parameter int Q_DEPTH    = 4,
  localparam int CNT_W     = $clog2(BUF_DEPTH + 1),
  localparam int BYTES_W   = $clog2(LINE_BYTES) + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [ADDR_W-1:0]         reqPc,
  input  logic [ADDR_W-1:0]         reqBase,
  input  logic [SLOT_W-1:0]         reqSlot,
  input  logic [CNT_W-1:0]          bufCount,
  input  logic [BUF_DEPTH*SZ_W-1:0] bufSizes,
  output logic                      txValid,
  input  logic                      txReady,
  output logic [ADDR_W-1:0]         txAddr,
  output logic [BYTES_W-1:0]        txBytes,
  output logic [SLOT_W-1:0]         txTag
);
  fag_pkg::fagStrobes_t strobes;
  logic qFull, qLast, stallQ;

  fag_control uControl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .txReady(txReady),
    .qFull(qFull), .qLast(qLast), .strobes(strobes),
    .reqReady(reqReady), .txValid(txValid), .stallQ(stallQ)
  );

  fag_datapath #(
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .BUF_DEPTH(BUF_DEPTH), .SZ_W(SZ_W),
    .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES), .Q_DEPTH(Q_DEPTH)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqPc(reqPc),
    .reqBase(reqBase), .reqSlot(reqSlot), .bufCount(bufCount),
    .bufSizes(bufSizes), .txAddr(txAddr), .txBytes(txBytes),
    .txTag(txTag), .qFull(qFull), .qLast(qLast)
  );
endmodule

// File: rtl/fag_checker.sv
module fag_checker #(
  parameter int ADDR_W     = 32,
  parameter int SLOT_W     = 4,
  parameter int LINE_BYTES = 64,
  localparam int LB        = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              txValid,
  input logic              txReady,
  input logic [ADDR_W-1:0] txAddr,
  input logic [LB:0]       txBytes,
  input logic [SLOT_W-1:0] txTag,
  input logic              stallQ
);
  // R9: refused request is re-offered unchanged
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txAddr) && $stable(txBytes) && $stable(txTag));

  // R3: an offered request never leaves its line
  assert_no_cross_R3: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (txBytes != '0) && (int'(txAddr[LB-1:0]) + int'(txBytes) <= LINE_BYTES));

  // R6: while stalled the port is kept busy with a queued request
  assert_stall_offers_R6: assert property (@(posedge clk) disable iff (!rstN)
    stallQ |-> txValid);

  // R7: a stall ends only after the port took a request
  assert_stall_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stallQ) |-> $past(txValid && txReady));

  // R8: a full queue only exists while stalled
  assert_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> stallQ);
endmodule

bind fag_top fag_checker #(
  .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .LINE_BYTES(LINE_BYTES)
) uChecker (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .txValid(txValid),
  .txReady(txReady), .txAddr(txAddr), .txBytes(txBytes), .txTag(txTag),
  .stallQ(stallQ)
);

// File: tb/tb_fag_top.sv
module tb_fag_top;
  localparam int ADDR_W = 32, SLOT_W = 4, BUF_DEPTH = 5, SZ_W = 4;
  localparam int LINE = 64, QD = 4;
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam longint AMASK = (longint'(1) << ADDR_W) - 1;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, txReady = 1;
  logic reqReady, txValid;
  logic [ADDR_W-1:0] reqPc = '0, reqBase = '0, txAddr;
  logic [SLOT_W-1:0] reqSlot = '0, txTag;
  logic [CNT_W-1:0] bufCount = '0;
  logic [BUF_DEPTH*SZ_W-1:0] bufSizes = '0;
  logic [$clog2(LINE):0] txBytes;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  fag_top #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .BUF_DEPTH(BUF_DEPTH),
            .SZ_W(SZ_W), .LINE_BYTES(LINE), .Q_DEPTH(QD)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqPc(reqPc), .reqBase(reqBase), .reqSlot(reqSlot),
    .bufCount(bufCount), .bufSizes(bufSizes), .txValid(txValid),
    .txReady(txReady), .txAddr(txAddr), .txBytes(txBytes), .txTag(txTag));

  typedef struct { longint addr; longint bytes; longint tag; } ment_t;
  ment_t mq[$];
  bit mStall = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic ment_t newReq();
    ment_t e;
    longint sum = 0, split;
    for (int i = 0; i < int'(bufCount); i++) sum += longint'(bufSizes[i*SZ_W +: SZ_W]);
    e.addr = (longint'(reqBase) + longint'(reqPc) + sum) & AMASK;
    split = ((e.addr + LINE - 1) / LINE) * LINE;
    e.bytes = (split > e.addr) ? split - e.addr : LINE;
    e.tag = longint'(reqSlot);
    return e;
  endfunction

  // Called just after a falling edge with inputs driven; compares and advances model.
  task automatic step(input string lbl);
    ment_t nr, ex;
    bit expValid, expReady;
    #2;
    nr = newReq();
    expReady = (mq.size() < QD);
    expValid = mStall || reqValid;
    ex = mStall ? mq[0] : nr;
    check(txValid == expValid, (lbl != "") ? lbl : (mStall ? "R6" : "R4"), "txValid", txValid, expValid);
    check(reqReady == expReady, (lbl != "") ? lbl : "R8", "reqReady", reqReady, expReady);
    if (expValid) begin
      check(longint'(txAddr) == ex.addr, (lbl != "") ? lbl : "R2", "txAddr", txAddr, ex.addr);
      check(longint'(txBytes) == ex.bytes, (lbl != "") ? lbl : "R3", "txBytes", txBytes, ex.bytes);
      check(longint'(txTag) == ex.tag, (lbl != "") ? lbl : (mStall ? "R6" : "R4"), "txTag", txTag, ex.tag);
    end
    if (mStall) begin
      if (txReady) void'(mq.pop_front());
      if (reqValid && expReady) mq.push_back(nr);
      mStall = (mq.size() > 0);
    end else if (reqValid && !txReady) begin
      mq.push_back(nr);
      mStall = 1;
    end
    @(negedge clk);
  endtask

  task automatic setReq(input bit v, input longint base, input longint pc, input int slot,
                        input int cnt, input logic [BUF_DEPTH*SZ_W-1:0] sizes, input bit rdy);
    reqValid = v; reqBase = ADDR_W'(base); reqPc = ADDR_W'(pc);
    reqSlot = SLOT_W'(slot); bufCount = CNT_W'(cnt); bufSizes = sizes; txReady = rdy;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txValid == 0 && reqReady == 1, "R1", "reset outputs", {txValid, reqReady}, 2'b01);
    rstN = 1;
    @(negedge clk);
    step("R1");

    // R2/R4: aligned, empty buffer, base added
    setReq(1, 'h1000, 'h40, 2, 0, '0, 1); step("R2");
    // R2/R3: buffered sizes 4,8,4 skipped; misaligned -> 44 bytes
    setReq(1, 'h1000, 'h44, 5, 3, {8'h00, 4'd4, 4'd8, 4'd4}, 1); step("R3");
    // R2: bufCount excludes later entries
    setReq(1, 'h200, 'h0, 1, 2, {4'd8, 4'd8, 4'd8, 4'd4, 4'd4}, 1); step("R2");
    // R3: top of address space, no wrap of the split point
    setReq(1, 'hFFFFFF00, 'hF8, 9, 0, '0, 1); step("R3");
    // R2: sum wraps modulo 2^32
    setReq(1, 'hFFFFFFF0, 'h20, 10, 0, '0, 1); step("R2");
    // R4: idle then direct request
    setReq(0, 0, 0, 0, 0, '0, 1); step("R4");
    setReq(1, 'h3000, 'h7C, 11, 1, 20'h00004, 1); step("R4");

    // R5: refusal enters queue
    setReq(1, 'h4000, 'h10, 3, 0, '0, 0); step("R5");
    // R9/R6: stalled, port holds slot 3, new grants queue behind
    setReq(1, 'h4000, 'h24, 4, 0, '0, 0); step("R9");
    setReq(1, 'h4000, 'h38, 5, 0, '0, 0); step("R6");
    setReq(1, 'h4000, 'h3C, 6, 0, '0, 0); step("R6");
    // R8: full, grant ignored
    setReq(1, 'h5000, 'h00, 7, 0, '0, 0); step("R8");
    setReq(1, 'h5000, 'h00, 7, 0, '0, 0); step("R8");
    // R7: drain in order; the ignored slot 7 must never appear
    setReq(0, 0, 0, 0, 0, '0, 1); step("R7");
    step("R7"); step("R7"); step("R7");
    setReq(1, 'h6000, 'h08, 12, 0, '0, 1); step("R7");
    // R7: drain while new grant appended in the same cycle
    setReq(1, 'h6000, 'h00, 13, 0, '0, 0); step("R5");
    setReq(1, 'h6000, 'h04, 14, 0, '0, 1); step("R7");
    setReq(0, 0, 0, 0, 0, '0, 1); step("R7");
    step("R7");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [BUF_DEPTH*SZ_W-1:0] sz;
      for (int k = 0; k < BUF_DEPTH; k++) sz[k*SZ_W +: SZ_W] = ($urandom_range(0, 1) != 0) ? 4'd8 : 4'd4;
      setReq($urandom_range(0, 1), longint'($urandom), longint'($urandom),
             int'($urandom_range(0, 15)), int'($urandom_range(0, BUF_DEPTH)), sz,
             $urandom_range(0, 9) < 6);
      step("");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule